// File: doc/BRIEF.md
# Reloadable Down-Counter Timer

This block is an 8-bit down-counter with a reload latch. It counts only on cycles where the chosen clock-enable source is high and the timer is running. On a count-enable while the counter holds zero, it reloads from the latch and raises a one-cycle underflow pulse. That pulse can feed a cascaded timer or an interrupt controller. A loaded value n therefore divides the selected enable rate by n+1.

A processor sets the count through a single write path. A mode bit travels with each write and chooses between two cases. In the first, only the reload latch takes the value, so a running count is left alone. In the second, both the latch and the live counter take the value, which is how a starting count is placed while the timer is stopped.

The source selector may change only while the timer is stopped. A separate event input is synchronised and edge-detected on an edge the user chooses, and it sets a sticky flag that a clear strobe resets.

Top module: `reload_timer`

## Requirements
- R1: With value n (0 to 255) in the latch and the counter, and the selected enable high on every cycle, underflow pulses occur exactly n+1 cycles apart.
- R2: While running, each cycle in which the selected enable is high decrements the counter by one. At zero it instead reloads the counter from the latch value held before that edge.
- R3: The underflow output is high for the single cycle after the edge on which a zero count was reloaded, and is low at all other times.
- R4: A write with `wr_latch_only`=1 changes only the latch, both running and stopped. The counter keeps decrementing or holding as if no write occurred.
- R5: A write with `wr_latch_only`=0 loads both latch and counter on the next edge. It takes precedence over a same-cycle count-enable, and that cycle produces no underflow.
- R6: While stopped (`running`=0), the counter keeps its value except for R5 writes, and no underflow occurs.
- R7: With `edge_rise`=0 a falling edge of `ext_in`, and with `edge_rise`=1 a rising edge, sets `evt_flag`. The flag rises three clock edges after the input changes: two synchroniser stages, then one flag register. `evt_clr` clears the flag, and a same-cycle edge wins over the clear.
- R8: A source-select write changes `src_sel` only when `running` is 0. When running it has no effect.
- R9: After reset, latch and counter read 0xFF, `running`=0, `src_sel`=0, and `evt_flag` and `underflow` are 0.
- R10: The count-enable is bit `src_sel` of `src_en`. All other bits of `src_en` have no effect.
- R11: `run_wr` loads `run_val` into `running` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NSRC (4) | Candidate count-enable sources |
| run_wr | input | 1 | Strobe to load the run bit |
| run_val | input | 1 | New run bit value |
| sel_wr | input | 1 | Strobe to write the source select |
| sel_val | input | SEL_W (2) | New source select |
| wr_en | input | 1 | Timer value write strobe |
| wr_latch_only | input | 1 | 1: latch only, 0: latch and counter |
| wr_data | input | CNT_W (8) | Value written |
| edge_rise | input | 1 | Event edge: 0 falling, 1 rising |
| ext_in | input | 1 | Asynchronous external event input |
| evt_clr | input | 1 | Clears the event flag |
| count | output | CNT_W (8) | Live counter value |
| latch | output | CNT_W (8) | Reload latch value |
| underflow | output | 1 | One-cycle underflow pulse |
| evt_flag | output | 1 | Sticky event flag |
| running | output | 1 | Run bit |
| src_sel | output | SEL_W (2) | Current source select |

## Verification
The bench targets the extremes of the divide ratio:
- n=0 should give an underflow on every enabled cycle.
- n=255 should give a 256-cycle period.

An off-by-one reload would instead show periods of n or n+2.

It also collides a latch-and-counter write with a zero-count enable. A design with the wrong priority would emit a stray underflow or reload the old latch. A latch-only write issued mid-count must not disturb the running count, and a design that loaded the counter would shorten the current period.

Select writes are issued during running, and other source bits toggle freely. A design that leaked the select or the unselected enables would count at the wrong rate. Both edge polarities, the synchroniser delay, and a clear colliding with an edge are exercised, so a wrong edge, a missing stage, or clear priority shows up at once.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic flag;
    } evt_state_t;

endpackage

// File: rtl/rt_event_edge.sv
module rt_event_edge
    import rt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic rise_sel_i,
    input  logic clr_i,
    output logic flag_o
);

    evt_state_t st_d, st_q;
    edge_sel_e  mode;
    logic       hit;

    always_comb begin
        mode = edge_sel_e'(rise_sel_i);
        if (mode == EDGE_RISE) begin
            hit = st_q.s2 & ~st_q.prev;
        end else begin
            hit = ~st_q.s2 & st_q.prev;
        end
        st_d.s1   = ext_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        st_d.flag = hit | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R7: a detected edge always leaves the flag set
    a_r7_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o);

endmodule

// File: rtl/rt_src_mux.sv
module rt_src_mux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSRC-1:0]  src_en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             run_i,
    output logic             tick_o
);

    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = src_en_i[i] & (sel_i == SEL_W'(i));
    end

    always_comb begin
        tick_o = run_i & (|hit);
    end

endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic             wr_latch_only_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] latch_o,
    output logic             uf_o
);

    localparam logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] latch;
        logic             uf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       load_cnt;

    always_comb begin
        load_cnt = wr_en_i & ~wr_latch_only_i;
        st_d     = st_q;
        st_d.uf  = 1'b0;
        if (wr_en_i) begin
            st_d.latch = wr_data_i;
        end
        if (load_cnt) begin
            st_d.cnt = wr_data_i;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.latch;
                st_d.uf  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= RST_VAL;
            st_q.latch <= RST_VAL;
            st_q.uf    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign latch_o = st_q.latch;
    assign uf_o    = st_q.uf;

    // R3: an underflow pulse comes with a counter freshly reloaded from the latch
    a_r3_uf_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |-> (cnt_o == $past(latch_o)));

    // R6: no enable and no counter write keeps the count and gives no pulse
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(wr_en_i && !wr_latch_only_i)) |=> (cnt_o == $past(cnt_o)) && !uf_o);

    // R4: a latch-only write lands in the latch
    a_r4_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_latch_only_i) |=> (latch_o == $past(wr_data_i)));

    // R5: a full write lands in the counter and suppresses underflow
    a_r5_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_latch_only_i) |=> (cnt_o == $past(wr_data_i)) && !uf_o);

endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int CNT_W = 8,
    parameter int NSRC  = 4,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_en,
    input  logic             run_wr,
    input  logic             run_val,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_val,
    input  logic             wr_en,
    input  logic             wr_latch_only,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             edge_rise,
    input  logic             ext_in,
    input  logic             evt_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latch,
    output logic             underflow,
    output logic             evt_flag,
    output logic             running,
    output logic [SEL_W-1:0] src_sel
);

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  tick;

    always_comb begin
        ctrl_d = ctrl_q;
        if (run_wr) begin
            ctrl_d.run = run_val;
        end
        if (sel_wr && !ctrl_q.run) begin
            ctrl_d.sel = sel_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign running = ctrl_q.run;
    assign src_sel = ctrl_q.sel;

    rt_src_mux #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W)
    ) u_src_mux (
        .src_en_i (src_en),
        .sel_i    (ctrl_q.sel),
        .run_i    (ctrl_q.run),
        .tick_o   (tick)
    );

    rt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .wr_en_i         (wr_en),
        .wr_latch_only_i (wr_latch_only),
        .wr_data_i       (wr_data),
        .cnt_o           (count),
        .latch_o         (latch),
        .uf_o            (underflow)
    );

    rt_event_edge u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_i      (ext_in),
        .rise_sel_i (edge_rise),
        .clr_i      (evt_clr),
        .flag_o     (evt_flag)
    );

    // R8: the selector is frozen across a running cycle
    a_r8_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(src_sel));

    // R6: a stopped timer never produces an underflow pulse
    a_r6_no_uf_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !underflow);

    // R11: the run bit follows its write strobe
    a_r11_run_write: assert property (@(posedge clk) disable iff (!rst_n)
        run_wr |=> (running == $past(run_val)));

endmodule

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;

    localparam int CNT_W = 8;
    localparam int NSRC  = 4;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_en = '0;
    logic             run_wr = 0, run_val = 0, sel_wr = 0;
    logic [SEL_W-1:0] sel_val = '0;
    logic             wr_en = 0, wr_latch_only = 0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             edge_rise = 0, ext_in = 0, evt_clr = 0;
    logic [CNT_W-1:0] count, latch;
    logic             underflow, evt_flag, running;
    logic [SEL_W-1:0] src_sel;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit rnd_src3 = 0;

    always #10 clk = ~clk;

    reload_timer #(.CNT_W(CNT_W), .NSRC(NSRC)) u_reload_timer (
        .clk, .rst_n, .src_en, .run_wr, .run_val, .sel_wr, .sel_val,
        .wr_en, .wr_latch_only, .wr_data, .edge_rise, .ext_in, .evt_clr,
        .count, .latch, .underflow, .evt_flag, .running, .src_sel
    );

    task automatic cmp(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_cnt = 255, m_latch = 255, m_uf = 0, m_run = 0, m_sel = 0, m_flag = 0;
    int syncq[$] = '{0, 0, 0};

    always @(posedge clk) begin
        int n_cnt, n_latch, n_uf, hit;
        bit tick, full;
        if (!rst_n) begin
            m_cnt = 255; m_latch = 255; m_uf = 0; m_run = 0; m_sel = 0; m_flag = 0;
            syncq = '{0, 0, 0};
        end else begin
            tick = (m_run != 0) && src_en[m_sel];
            full = wr_en && !wr_latch_only;
            n_uf = 0;
            n_cnt = m_cnt;
            n_latch = wr_en ? int'(wr_data) : m_latch;
            if (full) n_cnt = wr_data;
            else if (tick) begin
                if (m_cnt == 0) begin n_cnt = m_latch; n_uf = 1; end
                else n_cnt = m_cnt - 1;
            end
            if (edge_rise) hit = (syncq[1] == 1 && syncq[2] == 0);
            else           hit = (syncq[1] == 0 && syncq[2] == 1);
            m_flag = (hit != 0 || (m_flag != 0 && !evt_clr)) ? 1 : 0;
            syncq.push_front(int'(ext_in));
            void'(syncq.pop_back());
            if (sel_wr && m_run == 0) m_sel = sel_val;
            if (run_wr) m_run = run_val;
            m_cnt = n_cnt; m_latch = n_latch; m_uf = n_uf;
        end
    end

    // per-cycle comparison, between edges
    always @(posedge clk) begin
        #5;
        cmp("R2 count", count, m_cnt);
        cmp("R4 latch", latch, m_latch);
        cmp("R3 underflow", underflow, m_uf);
        cmp("R7 evt_flag", evt_flag, m_flag);
        cmp("R11 running", running, m_run);
        cmp("R8 src_sel", src_sel, m_sel);
    end

    // enable sources: bit0 always, bit1 every other, bit2 every third, bit3 random (R10)
    always @(negedge clk) begin
        cyc++;
        src_en <= {rnd_src3 ? 1'($urandom) : 1'b0, (cyc % 3) == 0, 1'(cyc), 1'b1};
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic twrite(input int d, input bit lonly);
        wr_en = 1; wr_latch_only = lonly; wr_data = d[CNT_W-1:0];
        step(1);
        wr_en = 0;
    endtask

    task automatic set_run(input bit v);
        run_wr = 1; run_val = v;
        step(1);
        run_wr = 0;
    endtask

    task automatic set_sel(input int s);
        sel_wr = 1; sel_val = s[SEL_W-1:0];
        step(1);
        sel_wr = 0;
    endtask

    task automatic measure(input string tag, input int exp);
        int k = 0;
        while (!underflow) step(1);
        step(1); k = 1;
        while (!underflow && k < 400) begin step(1); k++; end
        cmp(tag, k, exp);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int keep;
        step(3);
        rst_n = 1;
        step(1);
        // R9 reset state
        cmp("R9 count", count, 255);
        cmp("R9 latch", latch, 255);
        cmp("R9 running", running, 0);
        cmp("R9 src_sel", src_sel, 0);
        cmp("R9 flags", {evt_flag, underflow}, 0);

        // R5 full write while stopped, R6 hold
        twrite(5, 0);
        cmp("R5 count", count, 5);
        step(6);
        cmp("R6 stopped hold", count, 5);
        cmp("R6 no underflow", underflow, 0);

        // R1 period n+1 = 6
        set_run(1);
        measure("R1 period n=5", 6);

        // R4 latch-only write mid-count
        step(2);
        keep = count;
        twrite(2, 1);
        cmp("R4 counter untouched", count, (keep == 0) ? 5 : keep - 1);
        cmp("R4 latch", latch, 2);
        measure("R1 period n=2", 3);

        // R8 select write ignored while running
        set_sel(2);
        cmp("R8 ignored while running", src_sel, 0);
        set_run(0);
        keep = count;
        twrite(9, 1);
        cmp("R4 stopped latch-only", count, keep);
        set_sel(1);
        cmp("R8 written while stopped", src_sel, 1);

        // R10 other sources
        rnd_src3 = 1;
        set_run(1);
        step(40);
        set_run(0); set_sel(2); set_run(1);
        step(40);
        set_run(0); set_sel(3); set_run(1);
        step(40);
        set_run(0); set_sel(0);

        // R1 extremes
        twrite(0, 0);
        set_run(1);
        measure("R1 period n=0", 1);
        // R5 collision: full write against a zero-count enable
        twrite(7, 0);
        cmp("R5 no underflow on write", underflow, 0);
        cmp("R5 count", count, 7);
        twrite(255, 0);
        measure("R1 period n=255", 256);

        // R7 event edges
        set_run(0);
        edge_rise = 0; ext_in = 1; step(4);
        evt_clr = 1; step(1); evt_clr = 0;
        cmp("R7 cleared", evt_flag, 0);
        ext_in = 0; step(2);
        cmp("R7 not yet", evt_flag, 0);
        step(1);
        cmp("R7 falling sets", evt_flag, 1);
        evt_clr = 1; step(1); evt_clr = 0;
        edge_rise = 1; ext_in = 1; step(2);
        cmp("R7 rise pending", evt_flag, 0);
        step(1);
        cmp("R7 rising sets", evt_flag, 1);

        // random soak
        for (int i = 0; i < 600; i++) begin
            wr_en = ($urandom % 8) == 0;
            wr_latch_only = 1'($urandom);
            wr_data = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom % 12);
            run_wr = ($urandom % 16) == 0; run_val = 1'($urandom);
            sel_wr = ($urandom % 8) == 0; sel_val = 2'($urandom);
            edge_rise = ($urandom % 32 == 0) ? ~edge_rise : edge_rise;
            ext_in = 1'($urandom);
            evt_clr = ($urandom % 6) == 0;
            step(1);
        end
        wr_en = 0; run_wr = 0; sel_wr = 0; evt_clr = 0;
        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule